// File: doc/BRIEF.md
# Decode-Stage Operand Forwarding and Load Stall Unit

This block is the control part of operand bypassing for a five-stage, in-order, 32-bit pipeline that resolves register operands in the decode stage. It looks at the two source register numbers of the instruction in decode. For each instruction further down the pipe it also looks at the destination register, the register-write flag and the load flag. From these it picks, for each operand on its own, where the operand value comes from: the register file, the execute-stage result, the memory-stage result or the writeback data.

Data from a load only exists once the load reaches writeback. When the decode instruction needs the destination of a load that is still in execute or in memory, the unit holds the front of the pipe. It freezes the program counter and the fetch/decode register, and it asks for a bubble that clears the control fields sent on to execute. The unit has no state. Every output is a function of the present inputs.

Top module: `fwd_hazard_unit`

## Requirements
- R1: Register 0 is never forwarded. When a source register number is 0, its select is 0 (register file) whatever the later stages hold.
- R2: When several stages can supply the same register, the youngest one wins. The order is execute (code 1), then memory (code 2), then writeback (code 3), then the register file (code 0).
- R3: The two operand selects are worked out independently. They may name the same stage or different stages in the same cycle.
- R4: Execute is chosen (code 1) only when the execute instruction writes a register, is not a load, and has a nonzero destination equal to the source. Memory is chosen (code 2) under the same three conditions applied to the memory instruction.
- R5: Writeback is chosen (code 3) only when the writeback instruction writes a register and its nonzero destination equals the source. This holds for loads as well.
- R6: A load in the memory stage whose nonzero destination equals either source register causes a stall.
- R7: A load in the execute stage whose nonzero destination equals either source register causes a stall.
- R8: During a stall, pc_wr_en=0, ifid_wr_en=1'b0 and bubble=1. With no stall, pc_wr_en=1, ifid_wr_en=1 and bubble=0. The selects are only defined when there is no stall.
- R9: A stage whose register-write flag is low is never chosen. A later stage or the register file supplies the operand instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | 5 | First source register number of the decode instruction |
| src_b | input | 5 | Second source register number of the decode instruction |
| ex_dst | input | 5 | Destination register of the execute-stage instruction |
| ex_wr | input | 1 | Execute-stage instruction writes the register file |
| ex_ld | input | 1 | Execute-stage instruction is a load |
| mem_dst | input | 5 | Destination register of the memory-stage instruction |
| mem_wr | input | 1 | Memory-stage instruction writes the register file |
| mem_ld | input | 1 | Memory-stage instruction is a load |
| wb_dst | input | 5 | Destination register of the writeback-stage instruction |
| wb_wr | input | 1 | Writeback-stage instruction writes the register file |
| fwd_sel_a | output | 2 | Operand source for src_a: 0 file, 1 execute, 2 memory, 3 writeback |
| fwd_sel_b | output | 2 | Operand source for src_b, same encoding |
| pc_wr_en | output | 1 | Program counter may advance |
| ifid_wr_en | output | 1 | Fetch/decode register may load |
| bubble | output | 1 | Clear the control fields passed to execute |

## Verification
Two decisions can land in the same cycle. One is operand selection across several matching stages, where a stall decision may also be due. The other is one operand matching a pending load while the other operand matches an ordinary producer. Both are provoked by hand-built stage contents, and then by a sweep over every combination of registers 0 to 3 in all five register fields and every flag setting. On each clock a behavioural model scans the stages in age order and compares against the outputs. The selects are judged only in cycles where the model predicts no stall, and the stall controls are judged in every cycle.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_EX  = 2'd1,
    SRC_MEM = 2'd2,
    SRC_WB  = 2'd3
  } fwd_src_e;
endpackage

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel #(
  parameter int AW     = 5,
  parameter int NSTAGE = 3
) (
  input  logic [AW-1:0]         src,
  input  logic [NSTAGE-1:0][AW-1:0] dst,
  input  logic [NSTAGE-1:0]     usable,
  output fwd_pkg::fwd_src_e     sel
);
  import fwd_pkg::*;

  logic [NSTAGE-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NSTAGE; g++) begin : g_cmp
      assign hit[g] = usable[g] && (dst[g] != '0) && (dst[g] == src);
    end
  endgenerate

  // Stage 0 is the youngest; scan oldest first so younger hits override.
  always_comb begin
    sel = SRC_RF;
    for (int i = NSTAGE - 1; i >= 0; i--) begin
      if (hit[i]) sel = fwd_src_e'(i + 1);
    end
  end
endmodule

// File: rtl/fwd_load_hazard.sv
module fwd_load_hazard #(
  parameter int AW  = 5,
  parameter int NLD = 2
) (
  input  logic [AW-1:0]          src_a,
  input  logic [AW-1:0]          src_b,
  input  logic [NLD-1:0][AW-1:0] ld_dst,
  input  logic [NLD-1:0]         ld_flag,
  output logic                   stall
);
  logic [NLD-1:0] clash;

  genvar g;
  generate
    for (g = 0; g < NLD; g++) begin : g_ld
      assign clash[g] = ld_flag[g] && (ld_dst[g] != '0) &&
                        ((ld_dst[g] == src_a) || (ld_dst[g] == src_b));
    end
  endgenerate

  assign stall = |clash;
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src_a,
  input  logic [AW-1:0] src_b,
  input  logic [AW-1:0] ex_dst,
  input  logic          ex_wr,
  input  logic          ex_ld,
  input  logic [AW-1:0] mem_dst,
  input  logic          mem_wr,
  input  logic          mem_ld,
  input  logic [AW-1:0] wb_dst,
  input  logic          wb_wr,
  output logic [1:0]    fwd_sel_a,
  output logic [1:0]    fwd_sel_b,
  output logic          pc_wr_en,
  output logic          ifid_wr_en,
  output logic          bubble
);
  import fwd_pkg::*;

  localparam int NSTAGE = 3;
  localparam int NOPS   = 2;
  localparam int NLD    = 2;

  logic [NSTAGE-1:0][AW-1:0] stage_dst;
  logic [NSTAGE-1:0]         stage_ok;
  logic [NOPS-1:0][AW-1:0]   srcs;
  fwd_src_e                  sels [NOPS];
  logic                      stall;

  // Loads in execute or memory carry an address, not register data.
  assign stage_dst = {wb_dst, mem_dst, ex_dst};
  assign stage_ok  = {wb_wr, mem_wr && !mem_ld, ex_wr && !ex_ld};
  assign srcs      = {src_b, src_a};

  genvar g;
  generate
    for (g = 0; g < NOPS; g++) begin : g_op
      fwd_operand_sel #(.AW(AW), .NSTAGE(NSTAGE)) u_sel (
        .src    (srcs[g]),
        .dst    (stage_dst),
        .usable (stage_ok),
        .sel    (sels[g])
      );
    end
  endgenerate

  fwd_load_hazard #(.AW(AW), .NLD(NLD)) u_haz (
    .src_a   (src_a),
    .src_b   (src_b),
    .ld_dst  ({mem_dst, ex_dst}),
    .ld_flag ({mem_ld, ex_ld}),
    .stall   (stall)
  );

  assign fwd_sel_a  = sels[0];
  assign fwd_sel_b  = sels[1];
  assign pc_wr_en   = !stall;
  assign ifid_wr_en = !stall;
  assign bubble     = stall;
endmodule

// File: rtl/fwd_hazard_unit_chk.sv
module fwd_hazard_unit_chk #(
  parameter int AW = 5
) (
  input logic [AW-1:0] src_a,
  input logic [AW-1:0] src_b,
  input logic [AW-1:0] ex_dst,
  input logic          ex_wr,
  input logic          ex_ld,
  input logic [AW-1:0] mem_dst,
  input logic          mem_wr,
  input logic          mem_ld,
  input logic [AW-1:0] wb_dst,
  input logic          wb_wr,
  input logic [1:0]    fwd_sel_a,
  input logic [1:0]    fwd_sel_b,
  input logic          pc_wr_en,
  input logic          ifid_wr_en,
  input logic          bubble
);
  always_comb begin
    assert_zero_reg_a_R1: assert (src_a != '0 || fwd_sel_a == 2'd0);
    assert_zero_reg_b_R1: assert (src_b != '0 || fwd_sel_b == 2'd0);
    assert_ex_pick_R4: assert (fwd_sel_a != 2'd1 || (ex_wr && !ex_ld && ex_dst == src_a));
    assert_mem_pick_R4: assert (fwd_sel_b != 2'd2 || (mem_wr && !mem_ld && mem_dst == src_b));
    assert_wb_pick_R5: assert (fwd_sel_a != 2'd3 || (wb_wr && wb_dst == src_a));
    assert_mem_load_R6: assert (!(mem_ld && mem_dst != '0 && (mem_dst == src_a || mem_dst == src_b)) || bubble);
    assert_ex_load_R7: assert (!(ex_ld && ex_dst != '0 && (ex_dst == src_a || ex_dst == src_b)) || bubble);
    assert_stall_ctrl_R8: assert (pc_wr_en == ifid_wr_en && bubble == !pc_wr_en);
  end
endmodule

bind fwd_hazard_unit fwd_hazard_unit_chk #(.AW(AW)) u_chk (.*);

// File: tb/fwd_hazard_unit_bench.sv
module fwd_hazard_unit_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [4:0] src_a = '0, src_b = '0, ex_dst = '0, mem_dst = '0, wb_dst = '0;
  logic ex_wr = 0, ex_ld = 0, mem_wr = 0, mem_ld = 0, wb_wr = 0;
  logic [1:0] fwd_sel_a, fwd_sel_b;
  logic pc_wr_en, ifid_wr_en, bubble;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  fwd_hazard_unit u_fwd_hazard_unit (.*);

  function automatic int ref_sel(input int s);
    int d [3];
    bit ok [3];
    d[0] = ex_dst;  ok[0] = ex_wr && !ex_ld;
    d[1] = mem_dst; ok[1] = mem_wr && !mem_ld;
    d[2] = wb_dst;  ok[2] = wb_wr;
    for (int k = 0; k < 3; k++)
      if (s != 0 && ok[k] && d[k] == s) return k + 1;
    return 0;
  endfunction

  function automatic bit ref_stall();
    bit st = 0;
    if (ex_ld && ex_dst != 0 && (ex_dst == src_a || ex_dst == src_b)) st = 1;
    if (mem_ld && mem_dst != 0 && (mem_dst == src_a || mem_dst == src_b)) st = 1;
    return st;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_all(input int a, input int b,
                         input int ed, input bit ew, input bit el,
                         input int md, input bit mw, input bit ml,
                         input int wd, input bit ww);
    @(posedge clk);
    #1;
    src_a = 5'(a); src_b = 5'(b);
    ex_dst = 5'(ed); ex_wr = ew; ex_ld = el;
    mem_dst = 5'(md); mem_wr = mw; mem_ld = ml;
    wb_dst = 5'(wd); wb_wr = ww;
    @(negedge clk);
  endtask

  task automatic check_ctrl(input string req, input bit exp_stall);
    check(req, pc_wr_en, !exp_stall);
    check(req, ifid_wr_en, !exp_stall);
    check(req, bubble, exp_stall);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;

    // idle inputs after reset
    set_all(0,0, 0,0,0, 0,0,0, 0,0);
    check("R8 idle", {29'd0, bubble, pc_wr_en, ifid_wr_en}, 3);
    check("R8 idle sel", fwd_sel_a, 0);

    set_all(0,0, 0,1,0, 0,1,0, 0,1);
    check("R1 a", fwd_sel_a, 0);
    check("R1 b", fwd_sel_b, 0);

    set_all(2,2, 2,1,0, 2,1,0, 2,1);
    check("R2 ex wins", fwd_sel_a, 1);
    set_all(2,2, 3,1,0, 2,1,0, 2,1);
    check("R2 mem over wb", fwd_sel_b, 2);
    set_all(7,7, 3,1,0, 4,1,0, 7,1);
    check("R2 wb over file", fwd_sel_a, 3);

    set_all(1,2, 1,1,0, 5,0,0, 2,1);
    check("R3 a from ex", fwd_sel_a, 1);
    check("R3 b from wb", fwd_sel_b, 3);
    set_all(6,6, 9,1,0, 6,1,0, 1,1);
    check("R3 both mem a", fwd_sel_a, 2);
    check("R3 both mem b", fwd_sel_b, 2);

    set_all(4,9, 8,1,0, 9,1,0, 0,0);
    check("R4 mem", fwd_sel_b, 2);
    check("R4 no ex", fwd_sel_a, 0);

    set_all(5,3, 0,0,0, 0,0,0, 5,0);
    check("R5 wb off", fwd_sel_a, 0);
    set_all(5,3, 0,0,0, 0,0,0, 5,1);
    check("R5 wb on", fwd_sel_a, 3);
    set_all(5,3, 0,0,0, 0,0,0, 3,1);
    check("R5 wb b", fwd_sel_b, 3);

    set_all(1,4, 2,1,0, 4,1,1, 0,0);
    check_ctrl("R6 mem load", 1);
    set_all(1,4, 2,1,0, 0,1,1, 0,0);
    check_ctrl("R6 mem load r0", 0);

    set_all(3,1, 3,1,1, 0,0,0, 0,0);
    check_ctrl("R7 ex load", 1);
    set_all(3,1, 2,1,1, 0,0,0, 3,1);
    check_ctrl("R7 ex load other", 0);
    check("R7 other a wb", fwd_sel_a, 3);

    set_all(10,11, 10,0,0, 10,1,0, 10,1);
    check("R9 ex off", fwd_sel_a, 2);
    set_all(10,11, 11,0,0, 11,0,0, 11,0);
    check("R9 all off", fwd_sel_b, 0);

    // exhaustive sweep, registers 0..3, all flag settings
    for (int v = 0; v < 32768; v++) begin
      bit st;
      set_all(v & 3, (v >> 2) & 3, (v >> 4) & 3, v[10], v[11],
              (v >> 6) & 3, v[12], v[13], (v >> 8) & 3, v[14]);
      st = ref_stall();
      check("R8 sweep", {31'd0, bubble}, st);
      check("R8 sweep pc", {31'd0, pc_wr_en}, !st);
      if (!st) begin
        check("R2 sweep a", fwd_sel_a, ref_sel(src_a));
        check("R2 sweep b", fwd_sel_b, ref_sel(src_b));
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule